// File: doc/BRIEF.md
# Instruction Cache Line Lock Controller

This block is the control core of a small two-way set-associative instruction cache in which software can pin single lines. It holds the tag, valid and lock state for every line, a plain data array and one round-robin replacement pointer per set. It runs line fills over a word-wide memory bus. A command port carries a command code, a byte address and the privilege level of the issuing core. An address names the whole line that contains that byte.

A lock command either pins a resident line at once or fills the line from memory and then pins it. An unlock command returns a pinned line to ordinary use. An invalidate-all command drops every unpinned line. The replacement logic never evicts a pinned line. Two sticky error bits report a bus error during a lock fill and the case where a set has no unpinned way. Reading them clears them. A command from a non-privileged core does not execute and raises a program-exception pulse. A minimal fetch port returns hit and data, and it starts an ordinary unpinned fill on a miss.

Top module: `icache_lock_ctrl`

## Requirements
- R1: After reset every line is invalid and unlocked. `busy`, `mem_req`, `prog_exc`, `err_bus` and `err_noway` are all 0.
- R2: A byte address splits into word = bits [3:2], set = bits [6:4] and tag = bits [31:7]. Bits [1:0] are ignored, so every byte of a line selects the same line.
- R3: Command codes are 01 = lock, 10 = unlock and 11 = invalidate all; 00 is no command. A command accepted with `cmd_priv`=0 changes no cache state, starts no fill and sets no error. In that case `prog_exc` is 1 for exactly the cycle after acceptance.
- R4: A lock command that hits sets the line's lock bit. It completes without raising `busy` and sets no error bit.
- R5: A lock command that misses raises `busy` from the cycle after acceptance until the cycle after the last word is acknowledged. It reads the four words of the line in ascending order at line base + 4k. Only after the fourth word is written does the line become valid and locked.
- R6: The fill victim is the first unlocked way found from the set's round-robin pointer onward. After a completed fill the pointer moves to the way after the victim, so locked ways are never replaced.
- R7: Invalidate all clears the valid bit of every unlocked line. Locked lines stay valid, stay locked and keep hitting.
- R8: A `mem_err` on any acknowledged word of a lock fill ends the fill, leaves the target line invalid and unlocked, and sets the sticky `err_bus`. A bus error on a fetch-started fill only leaves the line invalid.
- R9: A lock command that misses in a set whose ways are all locked sets the sticky `err_noway` and starts no fill: `busy` and `mem_req` stay 0.
- R10: An unlock command that hits clears the lock bit and the line stays valid. One that misses changes nothing and sets no error. Neither raises `busy`.
- R11: A one-cycle `err_rd` pulse clears both error bits.
- R12: While the block is idle, `fetch_hit` and `fetch_data` answer a fetch in the same cycle. A fetch miss starts an unlocked fill, unless every way of the set is locked. While `busy` is 1, commands and fetches are ignored. A command has priority over a fetch in the same cycle, and `fetch_hit` is then 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_code | input | 2 | Command code |
| cmd_addr | input | 32 | Byte address selecting the line |
| cmd_priv | input | 1 | 1 = issuing core is privileged |
| err_rd | input | 1 | Error bits read strobe, clears them |
| err_bus | output | 1 | Sticky bus-error-during-lock-fill bit |
| err_noway | output | 1 | Sticky no-unlocked-way bit |
| prog_exc | output | 1 | Program exception pulse for a non-privileged command |
| busy | output | 1 | Line fill in progress |
| fetch_valid | input | 1 | Fetch request |
| fetch_addr | input | 32 | Fetch byte address |
| fetch_hit | output | 1 | Fetch hit this cycle |
| fetch_data | output | 32 | Fetched word |
| mem_req | output | 1 | Memory read request held during a fill |
| mem_addr | output | 32 | Memory word address |
| mem_rdata | input | 32 | Memory read data |
| mem_ack | input | 1 | Memory word acknowledge |
| mem_err | input | 1 | Bus error with the acknowledge |

## Verification
A wrong lock bit or a wrong replacement pointer shows only later. It appears as a fetch that misses on a pinned line, or hits on a line that should have been evicted, at the first fetch or invalidate after the fault. A wrong valid bit or tag shows on the next fetch to that line, as a hit flag or data word that differs from the memory contents. A fill state error shows within the fill itself as a wrong word address order, a `busy` that stays high, or an error bit that does not match. A wrong privilege decode shows in the cycle after the command, as a missing or spurious `prog_exc` pulse.

// File: rtl/icl_pkg.sv
package icl_pkg;
    localparam int unsigned WAYS   = 2;
    localparam int unsigned SETS   = 8;
    localparam int unsigned WORDS  = 4;
    localparam int unsigned DW     = 32;
    localparam int unsigned AW     = 32;
    localparam int unsigned WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int unsigned SET_W  = $clog2(SETS);
    localparam int unsigned WRD_W  = $clog2(WORDS);
    localparam int unsigned BYTE_W = $clog2(DW / 8);
    localparam int unsigned TAG_LSB = BYTE_W + WRD_W + SET_W;
    localparam int unsigned TAG_W  = AW - TAG_LSB;

    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [SET_W-1:0] set_t;
    typedef logic [WAY_W-1:0] way_t;
    typedef logic [WRD_W-1:0] wrd_t;
    typedef logic [DW-1:0]    word_t;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'b00,
        CMD_LOCK   = 2'b01,
        CMD_UNLOCK = 2'b10,
        CMD_INVAL  = 2'b11
    } cmd_e;

    typedef enum logic {ST_IDLE, ST_FILL} state_e;

    typedef struct packed {
        tag_t tag;
        set_t set;
        wrd_t wrd;
    } addr_t;

    typedef struct packed {
        tag_t tag;
        set_t set;
        way_t way;
        wrd_t wrd;
        logic lock;
    } fill_t;

    typedef struct packed {
        logic found;
        way_t way;
    } vic_t;

    function automatic addr_t split_addr(logic [AW-1:0] a);
        addr_t r;
        r.tag = a[AW-1:TAG_LSB];
        r.set = a[TAG_LSB-1:BYTE_W+WRD_W];
        r.wrd = a[BYTE_W+WRD_W-1:BYTE_W];
        return r;
    endfunction

    // First unlocked way at or after the pointer (WAYS is a power of two).
    function automatic vic_t pick_victim(way_t ptr, logic [WAYS-1:0] locked);
        vic_t r;
        way_t w;
        r = '0;
        for (int k = WAYS - 1; k >= 0; k--) begin
            w = way_t'(ptr + way_t'(k));
            if (!locked[w]) begin
                r.found = 1'b1;
                r.way   = w;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/icl_tag_store.sv
module icl_tag_store
    import icl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  addr_t lk,
    output logic  hit,
    output way_t  hit_way,
    output vic_t  vic,
    input  logic  do_lock,
    input  logic  do_unlock,
    input  logic  do_inval,
    input  logic  fill_start,
    input  logic  fill_done,
    input  fill_t fill
);
    tag_t            tag_q   [SETS][WAYS];
    logic [WAYS-1:0] valid_q [SETS];
    logic [WAYS-1:0] lock_q  [SETS];
    way_t            ptr_q   [SETS];

    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (valid_q[lk.set][w] && tag_q[lk.set][w] == lk.tag) begin
                hit     = 1'b1;
                hit_way = way_t'(w);
            end
        end
        vic = pick_victim(ptr_q[lk.set], lock_q[lk.set]);
    end

    always_ff @(posedge clk) begin
        if (fill_start) tag_q[lk.set][vic.way] <= lk.tag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                lock_q[s]  <= '0;
                ptr_q[s]   <= '0;
            end
        end else begin
            if (do_inval) begin
                for (int s = 0; s < SETS; s++) valid_q[s] <= valid_q[s] & lock_q[s];
            end
            if (do_lock)    lock_q[lk.set][hit_way] <= 1'b1;
            if (do_unlock)  lock_q[lk.set][hit_way] <= 1'b0;
            if (fill_start) valid_q[lk.set][vic.way] <= 1'b0;
            if (fill_done) begin
                valid_q[fill.set][fill.way] <= 1'b1;
                lock_q[fill.set][fill.way]  <= fill.lock;
                ptr_q[fill.set]             <= way_t'(fill.way + 1'b1);
            end
        end
    end

    // R6: a fill never starts on a locked way
    a_r6_victim_unlocked: assert property (@(posedge clk) disable iff (rst)
        fill_start |-> (vic.found && !lock_q[lk.set][vic.way]));

    generate
        for (genvar s = 0; s < SETS; s++) begin : g_chk
            for (genvar w = 0; w < WAYS; w++) begin : g_way
                // R7: a locked line is always resident
                a_r7_lock_implies_valid: assert property (@(posedge clk) disable iff (rst)
                    lock_q[s][w] |-> valid_q[s][w]);
            end
        end
    endgenerate
endmodule

// File: rtl/icl_data_store.sv
module icl_data_store
    import icl_pkg::*;
(
    input  logic  clk,
    input  logic  wr_en,
    input  fill_t wr_at,
    input  word_t wr_data,
    input  set_t  rd_set,
    input  way_t  rd_way,
    input  wrd_t  rd_wrd,
    output word_t rd_data
);
    word_t mem_q [SETS][WAYS][WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_at.set][wr_at.way][wr_at.wrd] <= wr_data;
    end

    assign rd_data = mem_q[rd_set][rd_way][rd_wrd];
endmodule

// File: rtl/icl_fill_ctrl.sv
module icl_fill_ctrl
    import icl_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_live,
    input  cmd_e          cmd_code,
    input  logic          cmd_priv,
    input  logic          fetch_valid,
    input  addr_t         lk,
    input  logic          hit,
    input  vic_t          vic,
    input  logic          err_rd,
    input  logic          mem_ack,
    input  logic          mem_err,
    output logic          busy,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic          prog_exc,
    output logic          err_bus,
    output logic          err_noway,
    output logic          do_lock,
    output logic          do_unlock,
    output logic          do_inval,
    output logic          fill_start,
    output logic          fill_done,
    output logic          dwr_en,
    output fill_t         fill
);
    state_e state_q;
    fill_t  fill_q;
    logic   accept, run, priv_bad, lock_miss, noway, fetch_miss, bus_fault;

    always_comb begin
        accept     = (state_q == ST_IDLE);
        priv_bad   = accept && cmd_live && !cmd_priv;
        run        = accept && cmd_live && cmd_priv;
        do_lock    = run && cmd_code == CMD_LOCK && hit;
        do_unlock  = run && cmd_code == CMD_UNLOCK && hit;
        do_inval   = run && cmd_code == CMD_INVAL;
        lock_miss  = run && cmd_code == CMD_LOCK && !hit;
        noway      = lock_miss && !vic.found;
        fetch_miss = accept && !cmd_live && fetch_valid && !hit && vic.found;
        fill_start = (lock_miss && vic.found) || fetch_miss;
        busy       = (state_q == ST_FILL);
        mem_req    = busy;
        mem_addr   = {fill_q.tag, fill_q.set, fill_q.wrd, {BYTE_W{1'b0}}};
        bus_fault  = busy && mem_ack && mem_err;
        dwr_en     = busy && mem_ack && !mem_err;
        fill_done  = dwr_en && fill_q.wrd == wrd_t'(WORDS - 1);
        fill       = fill_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            fill_q    <= '0;
            prog_exc  <= 1'b0;
            err_bus   <= 1'b0;
            err_noway <= 1'b0;
        end else begin
            prog_exc  <= priv_bad;
            err_bus   <= (err_bus && !err_rd) || (bus_fault && fill_q.lock);
            err_noway <= (err_noway && !err_rd) || noway;
            if (fill_start) begin
                state_q     <= ST_FILL;
                fill_q.tag  <= lk.tag;
                fill_q.set  <= lk.set;
                fill_q.way  <= vic.way;
                fill_q.wrd  <= '0;
                fill_q.lock <= lock_miss;
            end else if (busy && mem_ack) begin
                if (mem_err || fill_done) state_q <= ST_IDLE;
                else fill_q.wrd <= wrd_t'(fill_q.wrd + 1'b1);
            end
        end
    end

    // R3: the exception pulse follows a non-privileged command only
    a_r3_exc_cause: assert property (@(posedge clk) disable iff (rst)
        prog_exc |-> $past(cmd_live && !cmd_priv && !busy));
    // R5: a fill cannot end without a memory acknowledge
    a_r5_fill_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_ack) |=> busy);
    // R8: the bus error bit only rises after a faulted word
    a_r8_bus_err_src: assert property (@(posedge clk) disable iff (rst)
        $rose(err_bus) |-> $past(mem_ack && mem_err));
    // R9: a no-way error starts no fill
    a_r9_noway_no_fill: assert property (@(posedge clk) disable iff (rst)
        $rose(err_noway) |-> !mem_req);
endmodule

// File: rtl/icache_lock_ctrl.sv
module icache_lock_ctrl
    import icl_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_code,
    input  logic [AW-1:0] cmd_addr,
    input  logic          cmd_priv,
    input  logic          err_rd,
    output logic          err_bus,
    output logic          err_noway,
    output logic          prog_exc,
    output logic          busy,
    input  logic          fetch_valid,
    input  logic [AW-1:0] fetch_addr,
    output logic          fetch_hit,
    output logic [DW-1:0] fetch_data,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    input  logic          mem_err
);
    cmd_e  code;
    logic  cmd_live, hit, do_lock, do_unlock, do_inval, fill_start, fill_done, dwr_en;
    addr_t lk;
    way_t  hit_way;
    vic_t  vic;
    fill_t fill;

    assign code      = cmd_e'(cmd_code);
    assign cmd_live  = cmd_valid && code != CMD_NONE;
    assign lk        = split_addr(cmd_live ? cmd_addr : fetch_addr);
    assign fetch_hit = fetch_valid && !cmd_live && !busy && hit;

    icl_tag_store u_tags (
        .clk, .rst, .lk, .hit, .hit_way, .vic,
        .do_lock, .do_unlock, .do_inval, .fill_start, .fill_done, .fill
    );

    icl_data_store u_data (
        .clk, .wr_en(dwr_en), .wr_at(fill), .wr_data(mem_rdata),
        .rd_set(lk.set), .rd_way(hit_way), .rd_wrd(lk.wrd), .rd_data(fetch_data)
    );

    icl_fill_ctrl u_ctrl (
        .clk, .rst, .cmd_live, .cmd_code(code), .cmd_priv, .fetch_valid,
        .lk, .hit, .vic, .err_rd, .mem_ack, .mem_err,
        .busy, .mem_req, .mem_addr, .prog_exc, .err_bus, .err_noway,
        .do_lock, .do_unlock, .do_inval, .fill_start, .fill_done, .dwr_en, .fill
    );

    // R10: an accepted unlock never starts a fill
    a_r10_unlock_no_fill: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && code == CMD_UNLOCK && !busy) |=> !busy);
endmodule

// File: tb/test_icache_lock_ctrl.sv
module test_icache_lock_ctrl;
    import icl_pkg::*;

    logic clk = 1'b0, rst = 1'b1;
    logic cmd_valid = 0, cmd_priv = 0, err_rd = 0, fetch_valid = 0;
    logic [1:0] cmd_code = 0;
    logic [31:0] cmd_addr = 0, fetch_addr = 0, mem_rdata = 0, mem_addr;
    logic mem_ack = 0, mem_err = 0;
    logic err_bus, err_noway, prog_exc, busy, fetch_hit, mem_req;
    logic [31:0] fetch_data;

    always #2 clk = ~clk;

    icache_lock_ctrl i_icache_lock_ctrl (.*);

    int n_chk = 0, n_err = 0;
    int err_word = -1, lat = 0, nlog = 0;
    logic [31:0] mlog [8];
    bit done = 0;

    tag_t m_tag [SETS][WAYS];
    bit   m_val [SETS][WAYS];
    bit   m_lck [SETS][WAYS];
    int   m_ptr [SETS];
    bit   m_eb = 0, m_enw = 0;

    function automatic logic [31:0] memf(logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h0BAD_F00D;
    endfunction

    function automatic logic [31:0] mk(int t, int s, int w);
        return (32'(t) << 7) | (32'(s) << 4) | (32'(w) << 2);
    endfunction

    function automatic int m_hitway(logic [31:0] a);
        addr_t p = split_addr(a);
        for (int w = 0; w < WAYS; w++)
            if (m_val[p.set][w] && m_tag[p.set][w] == p.tag) return w;
        return -1;
    endfunction

    function automatic int m_victim(logic [31:0] a);
        addr_t p = split_addr(a);
        for (int k = 0; k < WAYS; k++) begin
            int w = (m_ptr[p.set] + k) % WAYS;
            if (!m_lck[p.set][w]) return w;
        end
        return -1;
    endfunction

    task automatic m_fill(logic [31:0] a, int v, bit lk);
        addr_t p = split_addr(a);
        m_tag[p.set][v] = p.tag;
        if (err_word >= 0) begin
            m_val[p.set][v] = 0;
            m_lck[p.set][v] = 0;
            if (lk) m_eb = 1;
        end else begin
            m_val[p.set][v] = 1;
            m_lck[p.set][v] = lk;
            m_ptr[p.set] = (v + 1) % WAYS;
        end
    endtask

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            mem_ack <= 0; mem_err <= 0;
        end else if (mem_ack) begin
            mem_ack <= 0; mem_err <= 0;
        end else if (mem_req) begin
            if (lat == 0) begin
                mem_ack   <= 1;
                mem_rdata <= memf(mem_addr);
                mem_err   <= (err_word == int'(mem_addr[3:2]));
                if (nlog < 8) mlog[nlog] = mem_addr;
                nlog++;
                lat = $urandom % 3;
            end else lat--;
        end
    end

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic check_errs(string req);
        check(err_bus == m_eb, {req, " err_bus"}, 32'(err_bus), 32'(m_eb));
        check(err_noway == m_enw, {req, " err_noway"}, 32'(err_noway), 32'(m_enw));
    endtask

    task automatic do_cmd(logic [1:0] code, logic [31:0] a, bit priv, string req);
        int hw = m_hitway(a), v = m_victim(a);
        bit fill = 0;
        @(negedge clk);
        cmd_valid = 1; cmd_code = code; cmd_addr = a; cmd_priv = priv;
        nlog = 0;
        @(negedge clk);
        cmd_valid = 0; cmd_code = 0;
        check(prog_exc == !priv, {req, " R3 prog_exc"}, 32'(prog_exc), 32'(!priv));
        if (priv) begin
            addr_t p = split_addr(a);
            case (code)
                2'b01: if (hw >= 0) m_lck[p.set][hw] = 1;
                       else if (v < 0) m_enw = 1;
                       else fill = 1;
                2'b10: if (hw >= 0) m_lck[p.set][hw] = 0;
                2'b11: for (int s = 0; s < SETS; s++)
                           for (int w = 0; w < WAYS; w++) m_val[s][w] &= m_lck[s][w];
                default: ;
            endcase
        end
        check(busy == fill, {req, " busy after command"}, 32'(busy), 32'(fill));
        wait_idle();
        if (fill) m_fill(a, v, 1);
        check_errs(req);
    endtask

    task automatic do_fetch(logic [31:0] a, string req);
        int hw = m_hitway(a), v = m_victim(a);
        bit fill = (hw < 0) && (v >= 0);
        @(negedge clk);
        fetch_valid = 1; fetch_addr = a; nlog = 0;
        #1;
        check(fetch_hit == (hw >= 0), {req, " R12 fetch_hit"}, 32'(fetch_hit), 32'(hw >= 0));
        if (hw >= 0)
            check(fetch_data == memf(a & ~32'h3), {req, " R12 fetch_data"}, fetch_data, memf(a & ~32'h3));
        @(negedge clk);
        fetch_valid = 0;
        check(busy == fill, {req, " R12 busy after fetch"}, 32'(busy), 32'(fill));
        wait_idle();
        if (fill) m_fill(a, v, 0);
    endtask

    task automatic read_err(string req);
        @(negedge clk);
        check_errs(req);
        err_rd = 1;
        @(negedge clk);
        err_rd = 0;
        m_eb = 0; m_enw = 0;
        check(!err_bus && !err_noway, {req, " R11 cleared"}, 32'({err_bus, err_noway}), 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=0", 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, b, c;
        void'($urandom(32'd1234));
        for (int s = 0; s < SETS; s++) begin
            m_ptr[s] = 0;
            for (int w = 0; w < WAYS; w++) begin m_val[s][w] = 0; m_lck[s][w] = 0; m_tag[s][w] = '0; end
        end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(!busy && !mem_req && !prog_exc && !err_bus && !err_noway, "R1 reset outputs",
              32'({busy, mem_req, prog_exc, err_bus, err_noway}), 32'h0);
        do_fetch(mk(1, 2, 1), "R1 empty cache");

        // R2: other bytes of the same line hit
        do_fetch(mk(1, 2, 3) | 32'h3, "R2 byte offset");
        do_fetch(mk(1, 2, 0) | 32'h1, "R2 word0");

        // R4: lock on hit
        do_cmd(2'b01, mk(1, 2, 2) | 32'h2, 1, "R4 lock hit");

        // R5: lock on miss fills then locks
        a = mk(3, 2, 2);
        do_cmd(2'b01, a, 1, "R5 lock miss");
        check(nlog == WORDS, "R5 word count", 32'(nlog), 32'(WORDS));
        for (int k = 0; k < WORDS; k++)
            check(mlog[k] == mk(3, 2, k), "R5 word order", mlog[k], mk(3, 2, k));
        do_fetch(a, "R5 locked line hits");

        // R9: no unlocked way
        do_cmd(2'b01, mk(5, 2, 0), 1, "R9 no way");
        check(nlog == 0, "R9 no bus cycle", 32'(nlog), 0);
        read_err("R11 after noway");

        // R7: invalidate keeps locked lines
        do_fetch(mk(2, 4, 0), "R7 unlocked line fill");
        do_cmd(2'b11, 0, 1, "R7 invalidate");
        do_fetch(mk(1, 2, 0), "R7 locked A survives");
        do_fetch(mk(3, 2, 3), "R7 locked B survives");
        do_fetch(mk(2, 4, 0), "R7 unlocked line gone");

        // R10: unlock hit and miss
        do_cmd(2'b10, mk(3, 2, 0), 1, "R10 unlock hit");
        do_fetch(mk(3, 2, 1), "R10 still valid");
        do_cmd(2'b10, mk(9, 6, 0), 1, "R10 unlock miss");
        do_cmd(2'b11, 0, 1, "R10 invalidate after unlock");
        do_fetch(mk(3, 2, 1), "R10 unlocked line dropped");

        // R3: user mode commands do nothing
        do_cmd(2'b01, mk(7, 1, 0), 0, "R3 user lock");
        check(nlog == 0, "R3 no fill", 32'(nlog), 0);
        do_cmd(2'b11, 0, 0, "R3 user invalidate");
        do_fetch(mk(1, 2, 0), "R3 state untouched");

        // R8: bus error on lock fill
        err_word = 2;
        do_cmd(2'b01, mk(4, 3, 0), 1, "R8 bus error");
        err_word = -1;
        do_fetch(mk(4, 3, 0), "R8 line not valid");
        read_err("R11 after bus error");
        err_word = 1;
        do_fetch(mk(6, 0, 0), "R8 fetch fill error");
        err_word = -1;
        check_errs("R8 fetch error silent");

        // R6: round robin skips locked way
        a = mk(1, 5, 0); b = mk(2, 5, 0); c = mk(3, 5, 0);
        do_cmd(2'b01, a, 1, "R6 lock A");
        do_fetch(b, "R6 fill B");
        do_fetch(c, "R6 fill C over B");
        do_fetch(a, "R6 A kept");
        do_fetch(b, "R6 B evicted");

        // R12: command wins over fetch in the same cycle
        @(negedge clk);
        cmd_valid = 1; cmd_code = 2'b10; cmd_addr = mk(9, 7, 0); cmd_priv = 1;
        fetch_valid = 1; fetch_addr = a;
        #1;
        check(!fetch_hit, "R12 command priority", 32'(fetch_hit), 0);
        @(negedge clk);
        cmd_valid = 0; cmd_code = 0; fetch_valid = 0;

        // random phase
        for (int i = 0; i < 400; i++) begin
            int r = $urandom % 12;
            logic [31:0] ra = mk($urandom % 3, $urandom % 4, $urandom % 4) | 32'($urandom % 4);
            bit pv = ($urandom % 8) != 0;
            if (($urandom % 10) == 0) err_word = $urandom % 4;
            if (r < 6) do_fetch(ra, "R12 random fetch");
            else if (r < 8) do_cmd(2'b01, ra, pv, "R5 random lock");
            else if (r < 10) do_cmd(2'b10, ra, pv, "R10 random unlock");
            else if (r == 10 && ($urandom % 3) == 0) do_cmd(2'b11, ra, pv, "R7 random invalidate");
            else read_err("R11 random read");
            err_word = -1;
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule